// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control Register

This block is the 16-bit basic control register of a 10/100 Ethernet PHY. A management front end, such as the serial management decoder of the PHY, presents a write strobe with 16 bits of data and continuously observes the register contents on a read bus. The register stores the mode bits that steer the rest of the PHY and drives each of them onto a dedicated output for the datapath.

Two bits trigger actions instead of holding a mode. Setting the soft-reset bit returns every mode bit to its default and opens a lockout window. The window lasts a fixed time, counted in clock cycles and derived from the clock period. During it, management writes are dropped and the reset bit reads as one. Setting the negotiation-restart bit produces a one-cycle pulse for the auto-negotiation engine, and the bit then clears itself.

The default of the isolate bit comes from the strapped PHY address. Address zero starts the PHY isolated; any other address starts it connected.

Top module: `phy_ctrl_reg`

## Requirements
- R1: Read bus bit positions are: 15 soft reset in progress, 14 loopback, 13 speed (1 = 100 Mb/s), 12 auto-negotiation enable, 11 low power, 10 isolate, 9 negotiation restart, 8 duplex (1 = full), 7 collision test. An accepted write with bit 15 at zero stores bits 14..10, 8 and 7 and shows them on the read bus from the next cycle.
- R2: Read bits 6..0 are always zero, whatever value is written to them.
- R3: After the hardware reset `rst_n`, the read bus holds 0x3000, with bit 10 set as R4 gives: speed and auto-negotiation enable are one, and all other bits are zero.
- R4: The isolate default is one when `strap_addr` equals 5'b00000 and zero for any other address. This default applies after both hardware reset and soft reset.
- R5: An accepted write with bit 15 set returns all mode bits to their defaults on the next cycle and ignores the other written bits. Bit 15 and `soft_reset_busy` then read one for exactly LOCK_CYCLES cycles and clear by themselves.
- R6: While the lockout is active, writes are dropped: no mode bit changes, no restart pulse is produced, and a new soft reset is not started.
- R7: An accepted write with bit 9 set (bit 15 clear) raises `an_restart_pulse` for exactly one cycle, the cycle after the write. Read bit 9 is one during that cycle only.
- R8: Writing zero to bit 15 or bit 9 starts no soft reset and no restart pulse.
- R9: The outputs `loopback`, `speed_100`, `an_enable`, `low_power`, `isolate`, `full_duplex` and `col_test` always equal their read-bus bits.
- R10: LOCK_CYCLES equals LOCK_NS times 1000 divided by CLK_PERIOD_PS, rounded up. This gives 64 cycles for 640 ns at 10 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_addr | input | 5 | Strapped PHY address, selects the isolate default |
| wr_en | input | 1 | Write strobe from the management front end |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| an_restart_pulse | output | 1 | One-cycle request to restart auto-negotiation |
| soft_reset_busy | output | 1 | High during the soft-reset lockout |
| loopback | output | 1 | Loopback mode |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| an_enable | output | 1 | Auto-negotiation enable |
| low_power | output | 1 | Low-power mode |
| isolate | output | 1 | Isolate the PHY from its MAC interface |
| full_duplex | output | 1 | 1 = full duplex |
| col_test | output | 1 | Collision test mode |

## Verification
The hardest case to reach is a write that arrives inside the lockout window. It must leave the defaults untouched, produce no restart pulse, and not stretch the window. To reach it, the stimulus starts a soft reset and then, while bit 15 is still high, issues a mode write, a restart write and a second soft-reset write. It then counts how many cycles bit 15 stays high. A bench model with its own cycle counter is compared with the read bus and the mode outputs on every clock.

// File: rtl/phy_ctrl_pkg.sv
`timescale 1ns/1ps
package phy_ctrl_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned B_SRST     = 15;
  localparam int unsigned B_LOOP     = 14;
  localparam int unsigned B_SPEED    = 13;
  localparam int unsigned B_ANEN     = 12;
  localparam int unsigned B_LOWPWR   = 11;
  localparam int unsigned B_ISO      = 10;
  localparam int unsigned B_RESTART  = 9;
  localparam int unsigned B_DUPLEX   = 8;
  localparam int unsigned B_COLTEST  = 7;

  typedef struct packed {
    logic loopback;
    logic speed_100;
    logic an_enable;
    logic low_power;
    logic isolate;
    logic full_duplex;
    logic col_test;
  } mode_t;

  function automatic mode_t mode_defaults(input logic iso_dflt);
    mode_t m;
    m.loopback    = 1'b0;
    m.speed_100   = 1'b1;
    m.an_enable   = 1'b1;
    m.low_power   = 1'b0;
    m.isolate     = iso_dflt;
    m.full_duplex = 1'b0;
    m.col_test    = 1'b0;
    return m;
  endfunction

  function automatic mode_t mode_from_word(input logic [REG_W-1:0] w);
    mode_t m;
    m.loopback    = w[B_LOOP];
    m.speed_100   = w[B_SPEED];
    m.an_enable   = w[B_ANEN];
    m.low_power   = w[B_LOWPWR];
    m.isolate     = w[B_ISO];
    m.full_duplex = w[B_DUPLEX];
    m.col_test    = w[B_COLTEST];
    return m;
  endfunction
endpackage

// File: rtl/phy_ctrl_lockout.sv
`timescale 1ns/1ps
module phy_ctrl_lockout #(
  parameter int unsigned CLK_PERIOD_PS = 40000,
  parameter int unsigned LOCK_NS       = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned LOCK_CYCLES = (LOCK_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(LOCK_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_no_restart_in_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/phy_ctrl_modes.sv
`timescale 1ns/1ps
module phy_ctrl_modes
  import phy_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iso_dflt_i,
  input  logic             load_dflt_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output mode_t            mode_o,
  output logic             restart_o
);
  mode_t mode_q;
  logic  restart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= mode_defaults(iso_dflt_i);
      restart_q <= 1'b0;
    end else if (load_dflt_i) begin
      mode_q    <= mode_defaults(iso_dflt_i);
      restart_q <= 1'b0;
    end else if (wr_i) begin
      mode_q    <= mode_from_word(wdata_i);
      restart_q <= wdata_i[B_RESTART];
    end else begin
      restart_q <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign restart_o = restart_q;

  assert_restart_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !load_dflt_i && wdata_i[B_RESTART]) |=> restart_o);
endmodule

// File: rtl/phy_ctrl_reg.sv
`timescale 1ns/1ps
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 40000,
  parameter int unsigned LOCK_NS       = 640,
  parameter int unsigned ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              an_restart_pulse,
  output logic              soft_reset_busy,
  output logic              loopback,
  output logic              speed_100,
  output logic              an_enable,
  output logic              low_power,
  output logic              isolate,
  output logic              full_duplex,
  output logic              col_test
);
  logic  busy;
  logic  accept;
  logic  start_srst;
  logic  wr_mode;
  logic  iso_dflt;
  logic  restart;
  mode_t mode;

  assign iso_dflt   = (strap_addr == '0);
  assign accept     = wr_en && !busy;
  assign start_srst = accept && wr_data[B_SRST];
  assign wr_mode    = accept && !wr_data[B_SRST];

  phy_ctrl_lockout #(
    .CLK_PERIOD_PS(CLK_PERIOD_PS),
    .LOCK_NS      (LOCK_NS)
  ) u_lockout (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_srst),
    .busy_o (busy)
  );

  phy_ctrl_modes u_modes (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_dflt_i (iso_dflt),
    .load_dflt_i(start_srst),
    .wr_i       (wr_mode),
    .wdata_i    (wr_data),
    .mode_o     (mode),
    .restart_o  (restart)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[B_SRST]    = busy;
    rd_data[B_LOOP]    = mode.loopback;
    rd_data[B_SPEED]   = mode.speed_100;
    rd_data[B_ANEN]    = mode.an_enable;
    rd_data[B_LOWPWR]  = mode.low_power;
    rd_data[B_ISO]     = mode.isolate;
    rd_data[B_RESTART] = restart;
    rd_data[B_DUPLEX]  = mode.full_duplex;
    rd_data[B_COLTEST] = mode.col_test;
  end

  assign an_restart_pulse = restart;
  assign soft_reset_busy  = busy;
  assign loopback         = mode.loopback;
  assign speed_100        = mode.speed_100;
  assign an_enable        = mode.an_enable;
  assign low_power        = mode.low_power;
  assign isolate          = mode.isolate;
  assign full_duplex      = mode.full_duplex;
  assign col_test         = mode.col_test;

  assert_lock_holds_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_busy |-> (mode == mode_defaults(iso_dflt)));
  assert_lock_freezes_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_reset_busy && $past(soft_reset_busy)) |-> $stable(rd_data[14:0]));
  assert_no_pulse_in_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_busy |-> !an_restart_pulse);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_pulse |=> !an_restart_pulse);
  assert_zero_write_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[9]) |=> !an_restart_pulse);
  assert_zero_write_no_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_reset_busy && !wr_data[15]) |=> !soft_reset_busy);
endmodule

// File: tb/phy_ctrl_reg_bench.sv
`timescale 1ns/1ps
module phy_ctrl_reg_bench;
  localparam int EXP_LOCK = 64; // R10: 640 ns at a 10 ns clock

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = 5'h03;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic an_restart_pulse, soft_reset_busy, loopback, speed_100, an_enable;
  logic low_power, isolate, full_duplex, col_test;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  phy_ctrl_reg #(.CLK_PERIOD_PS(10000), .LOCK_NS(640)) u_phy_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .an_restart_pulse(an_restart_pulse), .soft_reset_busy(soft_reset_busy),
    .loopback(loopback), .speed_100(speed_100), .an_enable(an_enable), .low_power(low_power),
    .isolate(isolate), .full_duplex(full_duplex), .col_test(col_test));

  // Behavioural reference: stored mode word, lockout cycles left, pulse flag.
  logic [15:0] m_cfg;
  int          m_left;
  logic        m_pulse;

  function automatic logic [15:0] dflt_word(input logic [4:0] a);
    return 16'h3000 | ((a == 5'd0) ? 16'h0400 : 16'h0000);
  endfunction

  function automatic logic [15:0] exp_rd();
    return m_cfg | (m_left > 0 ? 16'h8000 : 16'h0) | (m_pulse ? 16'h0200 : 16'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = dflt_word(strap_addr); m_left = 0; m_pulse = 1'b0;
    end else if (m_left > 0) begin
      m_left = m_left - 1; m_pulse = 1'b0;
    end else if (wr_en && wr_data[15]) begin
      m_cfg = dflt_word(strap_addr); m_left = EXP_LOCK; m_pulse = 1'b0;
    end else if (wr_en) begin
      m_cfg = wr_data & 16'h7D80; m_pulse = wr_data[9];
    end else begin
      m_pulse = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 R2 rd_data vs model", rd_data, exp_rd());
      check("R9 mode outputs", {9'd0, loopback, speed_100, an_enable, low_power, isolate, full_duplex, col_test},
            {9'd0, rd_data[14], rd_data[13], rd_data[12], rd_data[11], rd_data[10], rd_data[8], rd_data[7]});
      check("R5 busy output", {15'd0, soft_reset_busy}, {15'd0, rd_data[15]});
      check("R7 pulse output", {15'd0, an_restart_pulse}, {15'd0, m_pulse});
    end
  end

  task automatic do_write(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic hw_reset(input logic [4:0] a);
    @(negedge clk); rst_n = 1'b0; strap_addr = a;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int len;
    hw_reset(5'h03);
    check("R3 R4 default nonzero addr", rd_data, 16'h3000);
    hw_reset(5'h00);
    check("R3 R4 default zero addr", rd_data, 16'h3400);

    do_write(16'h41FF);
    check("R1 R2 write loop/dup/coltest, reserved dropped", rd_data, 16'h4180);
    do_write(16'h1C00);
    check("R1 write an_en/lowpwr/iso", rd_data, 16'h1C00);

    do_write(16'h2B00);
    check("R7 restart bit visible", rd_data, 16'h2B00);
    check("R7 pulse high", {15'd0, an_restart_pulse}, 16'd1);
    @(negedge clk);
    check("R7 restart self-clears", rd_data, 16'h2900);
    check("R7 pulse one cycle", {15'd0, an_restart_pulse}, 16'd0);

    do_write(16'h0000);
    check("R8 zero write no reset", {15'd0, soft_reset_busy}, 16'd0);
    check("R8 zero write no pulse", {15'd0, an_restart_pulse}, 16'd0);

    do_write(16'hFFFF);
    check("R5 soft reset defaults", rd_data, 16'hB400);
    len = 1;
    do_write(16'h4180);
    len += 2;
    check("R6 write in lockout ignored", rd_data, 16'hB400);
    do_write(16'h0200);
    len += 2;
    check("R6 no pulse in lockout", {15'd0, an_restart_pulse}, 16'd0);
    do_write(16'h8000);
    len += 2;
    while (rd_data[15] && len < 1000) begin
      @(negedge clk); len++;
    end
    check("R5 R10 lockout length", 16'(len - 1), 16'(EXP_LOCK));
    check("R5 defaults after lockout", rd_data, 16'h3400);

    hw_reset(5'h11);
    do_write(16'h8400);
    check("R4 soft reset isolate default nonzero addr", rd_data, 16'hB000);
    repeat (EXP_LOCK + 2) @(negedge clk);
    do_write(16'h0500);
    check("R1 write after lockout accepted", rd_data, 16'h0500);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule